// File: doc/BRIEF.md
# Random Access Sequence Server

This block is the source side of a streamed memory. A producer loads one sequence of 8-bit elements into a small internal buffer through a valid/ready load stream; the final element is flagged with a last bit. The block then offers the sequence length on a forward length stream. Only after the sink has taken that length does the block accept element indices on a reverse request stream. It answers each request with exactly one element on a forward response stream.

Each request carries a last bit that closes the session. Once the response to that final request has been accepted, the buffer is cleared and the block accepts the next sequence. An index at or beyond the announced length does not stall the block. It is answered with a zero element and an error flag.

Back-pressure rules are as follows. Every stream moves a transfer on a rising edge where both valid and ready are high. The length and the response are held unchanged while ready is low. The block keeps only one request outstanding, so request ready stays low from the accepted request until its response has been taken. The ready signals of the block do not depend on its inputs in the same cycle. A source may therefore wait for ready before raising valid. The block never waits for a later stream before an earlier one: load, then length, then requests and responses in turn.

Top module: `seq_access_server`

## Requirements
- R1: While and right after reset, ld_ready is 1 and len_valid, req_ready and rsp_valid are 0.
- R2: The length is offered one cycle after the load beat with ld_last=1 is accepted. It equals the number of stored elements and stays stable until accepted.
- R3: req_ready stays 0 until the length has been accepted and rises in the next cycle. ld_ready is 0 from the final load beat until the session closes.
- R4: A request with index below the length returns the element loaded at that position (the first loaded element is index 0), with rsp_err=0. rsp_valid rises one cycle after the request is accepted.
- R5: A request with index equal to or above the length returns rsp_data=0 with rsp_err=1.
- R6: While a response is pending, req_ready is 0, and rsp_data and rsp_err stay stable until rsp_ready is high.
- R7: One cycle after the response to a request with req_last=1 is accepted, ld_ready returns to 1 and no length is offered. The next load fully replaces the old sequence.
- R8: Load beats beyond DEPTH elements are accepted but not stored, and the length saturates at DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Load beat valid |
| ld_ready | output | 1 | Block accepts load beats |
| ld_data | input | ELEM_W | Element being loaded |
| ld_last | input | 1 | Final element of the sequence |
| len_valid | output | 1 | Length offered |
| len_ready | input | 1 | Sink takes the length |
| len_data | output | IDX_W | Number of stored elements |
| req_valid | input | 1 | Request valid (sink to block) |
| req_ready | output | 1 | Block accepts a request |
| req_index | input | IDX_W | Requested element position |
| req_last | input | 1 | Final request of the session |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Sink takes the response |
| rsp_data | output | ELEM_W | Element, or 0 on error |
| rsp_err | output | 1 | Index was out of range |

## Verification
Three results are due one cycle after their cause. The length follows the final load beat, a response follows an accepted request, and load readiness follows the final response. Request readiness is likewise due one cycle after the length is taken. The bench drives inputs on falling edges and waits there for ready. A transfer therefore takes place on the following rising edge, and each of these one-cycle results is checked on the falling edge right after it. Responses are checked by a monitor that compares each accepted response in order against a queue of expected elements. The queue is filled by the request driver from its own copy of the loaded data, while the sink's readiness is toggled pseudo-randomly.

// File: rtl/seq_srv_pkg.sv
package seq_srv_pkg;
  typedef enum logic [1:0] {
    ST_LOAD     = 2'd0,
    ST_ANNOUNCE = 2'd1,
    ST_SERVE    = 2'd2,
    ST_RESP     = 2'd3
  } srv_state_t;
endpackage

// File: rtl/seq_store.sv
module seq_store #(
  parameter int ELEM_W = 8,
  parameter int IDX_W  = 5,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              wr_en,
  input  logic [ELEM_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [IDX_W-1:0]  count,
  output logic [ELEM_W-1:0] rd_data,
  output logic              in_range
);
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [IDX_W-1:0] FULL_CNT = IDX_W'(DEPTH);

  logic [ELEM_W-1:0] mem [DEPTH];
  logic [IDX_W-1:0]  cnt;
  logic              full;

  assign full = (cnt == FULL_CNT);

  // one write-enabled register per entry
  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (wr_en && !full && (cnt == IDX_W'(g)))
        mem[g] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear)
      cnt <= '0;
    else if (wr_en && !full)
      cnt <= cnt + 1'b1;
  end

  assign count    = cnt;
  assign in_range = (rd_idx < cnt);
  assign rd_data  = mem[rd_idx[ADDR_W-1:0]];
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import seq_srv_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ld_valid,
  input  logic ld_last,
  input  logic len_ready,
  input  logic req_valid,
  input  logic req_last,
  input  logic rsp_ready,
  output logic ld_ready,
  output logic len_valid,
  output logic req_ready,
  output logic rsp_valid,
  output logic wr_en,
  output logic req_fire,
  output logic seq_done
);
  srv_state_t state;
  logic       last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_LOAD;
      last_q <= 1'b0;
    end else begin
      case (state)
        ST_LOAD:     if (ld_valid && ld_last) state <= ST_ANNOUNCE;
        ST_ANNOUNCE: if (len_ready) state <= ST_SERVE;
        ST_SERVE: begin
          if (req_valid) begin
            state  <= ST_RESP;
            last_q <= req_last;
          end
        end
        ST_RESP:     if (rsp_ready) state <= last_q ? ST_LOAD : ST_SERVE;
        default:     state <= ST_LOAD;
      endcase
    end
  end

  assign ld_ready  = (state == ST_LOAD);
  assign len_valid = (state == ST_ANNOUNCE);
  assign req_ready = (state == ST_SERVE);
  assign rsp_valid = (state == ST_RESP);
  assign wr_en     = ld_valid && ld_ready;
  assign req_fire  = req_valid && req_ready;
  assign seq_done  = rsp_valid && rsp_ready && last_q;
endmodule

// File: rtl/seq_resp.sv
module seq_resp #(
  parameter int ELEM_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic              in_range,
  input  logic [ELEM_W-1:0] rd_data,
  output logic [ELEM_W-1:0] rsp_data,
  output logic              rsp_err
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_data <= '0;
      rsp_err  <= 1'b0;
    end else if (capture) begin
      rsp_data <= in_range ? rd_data : '0;
      rsp_err  <= !in_range;
    end
  end
endmodule

// File: rtl/seq_access_server.sv
module seq_access_server #(
  parameter int ELEM_W = 8,
  parameter int IDX_W  = 5,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic [ELEM_W-1:0] ld_data,
  input  logic              ld_last,
  output logic              len_valid,
  input  logic              len_ready,
  output logic [IDX_W-1:0]  len_data,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [IDX_W-1:0]  req_index,
  input  logic              req_last,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ELEM_W-1:0] rsp_data,
  output logic              rsp_err
);
  logic              wr_en;
  logic              req_fire;
  logic              seq_done;
  logic              in_range;
  logic [ELEM_W-1:0] rd_data;

  seq_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_valid  (ld_valid),
    .ld_last   (ld_last),
    .len_ready (len_ready),
    .req_valid (req_valid),
    .req_last  (req_last),
    .rsp_ready (rsp_ready),
    .ld_ready  (ld_ready),
    .len_valid (len_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .wr_en     (wr_en),
    .req_fire  (req_fire),
    .seq_done  (seq_done)
  );

  seq_store #(.ELEM_W(ELEM_W), .IDX_W(IDX_W), .DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (seq_done),
    .wr_en    (wr_en),
    .wr_data  (ld_data),
    .rd_idx   (req_index),
    .count    (len_data),
    .rd_data  (rd_data),
    .in_range (in_range)
  );

  seq_resp #(.ELEM_W(ELEM_W)) u_resp (
    .clk      (clk),
    .rst_n    (rst_n),
    .capture  (req_fire),
    .in_range (in_range),
    .rd_data  (rd_data),
    .rsp_data (rsp_data),
    .rsp_err  (rsp_err)
  );
endmodule

// File: rtl/seq_access_server_chk.sv
module seq_access_server_chk #(
  parameter int ELEM_W = 8,
  parameter int IDX_W  = 5,
  parameter int DEPTH  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ld_ready,
  input logic              len_valid,
  input logic              len_ready,
  input logic [IDX_W-1:0]  len_data,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_last,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [ELEM_W-1:0] rsp_data,
  input logic              rsp_err
);
  logic last_seen;

  always_ff @(posedge clk) begin
    if (!rst_n)
      last_seen <= 1'b0;
    else if (req_valid && req_ready)
      last_seen <= req_last;
  end

  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |=> (ld_ready && !len_valid && !req_ready && !rsp_valid));

  a_r2_len_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (len_valid && !len_ready) |=> (len_valid && $stable(len_data)));

  a_r3_no_req_before_len: assert property (@(posedge clk) disable iff (!rst_n)
    (len_valid || ld_ready) |-> !req_ready);

  a_r3_req_after_len: assert property (@(posedge clk) disable iff (!rst_n)
    (len_valid && len_ready) |=> req_ready);

  a_r4_resp_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  a_r5_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (rsp_data == '0));

  a_r6_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  a_r6_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_err)));

  a_r7_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ready && last_seen) |=> (ld_ready && !len_valid));

  a_r8_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
    len_valid |-> (len_data <= IDX_W'(DEPTH)));
endmodule

bind seq_access_server seq_access_server_chk #(
  .ELEM_W(ELEM_W), .IDX_W(IDX_W), .DEPTH(DEPTH)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ld_ready  (ld_ready),
  .len_valid (len_valid),
  .len_ready (len_ready),
  .len_data  (len_data),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_last  (req_last),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_data  (rsp_data),
  .rsp_err   (rsp_err)
);

// File: tb/seq_access_server_test.sv
module seq_access_server_test;
  localparam int ELEM_W = 8;
  localparam int IDX_W  = 5;
  localparam int DEPTH  = 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst_n = 1'b0;
  logic              ld_valid = 1'b0, ld_last = 1'b0;
  logic [ELEM_W-1:0] ld_data = '0;
  logic              len_ready = 1'b0;
  logic              req_valid = 1'b0, req_last = 1'b0;
  logic [IDX_W-1:0]  req_index = '0;
  logic              rsp_ready = 1'b1;
  logic              ld_ready, len_valid, req_ready, rsp_valid, rsp_err;
  logic [IDX_W-1:0]  len_data;
  logic [ELEM_W-1:0] rsp_data;

  seq_access_server #(.ELEM_W(ELEM_W), .IDX_W(IDX_W), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_data(ld_data), .ld_last(ld_last),
    .len_valid(len_valid), .len_ready(len_ready), .len_data(len_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_index(req_index), .req_last(req_last),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_err(rsp_err)
  );

  int n_cmp = 0;
  int n_bad = 0;
  logic [ELEM_W:0]   expq [$];
  logic [ELEM_W:0]   e;
  logic [ELEM_W-1:0] model [32];
  int                cur_len = 0;
  bit                bp_mode = 1'b0;
  logic [7:0]        lfsr = 8'h5A;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // sink readiness, changed just after rising edges
  always @(posedge clk) begin
    #1;
    lfsr      <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    rsp_ready <= bp_mode ? lfsr[0] : 1'b1;
  end

  // scoreboard monitor: a response transfers on the next rising edge
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (expq.size() == 0) begin
        check(1'b0, "R4 unexpected response", int'({rsp_err, rsp_data}), -1);
      end else begin
        e = expq.pop_front();
        check({rsp_err, rsp_data} == e,
              e[ELEM_W] ? "R5 out-of-range response" : "R4 in-range response",
              int'({rsp_err, rsp_data}), int'(e));
      end
    end
  end

  task automatic load_seq(input int n, input int seed);
    for (int i = 0; i < n; i++) begin
      logic [7:0] b;
      b = 8'(seed * 7 + i * 13 + 1);
      @(negedge clk);
      ld_valid = 1'b1;
      ld_data  = b;
      ld_last  = (i == n - 1);
      while (!ld_ready) @(negedge clk);
      if (i < DEPTH) model[i] = b;
    end
    @(negedge clk);
    ld_valid = 1'b0;
    ld_last  = 1'b0;
    cur_len  = (n > DEPTH) ? DEPTH : n;
    check(len_valid == 1'b1, "R2 length offered one cycle after final load beat", int'(len_valid), 1);
    check(ld_ready == 1'b0, "R3 load closed after final beat", int'(ld_ready), 0);
    check(req_ready == 1'b0, "R3 no request ready before length", int'(req_ready), 0);
  endtask

  task automatic take_len(input int hold);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      check(len_valid && (int'(len_data) == cur_len), "R2 length held under back-pressure",
            int'(len_data), cur_len);
      check(!req_ready, "R3 request closed while length pending", int'(req_ready), 0);
    end
    check(int'(len_data) == cur_len, "R2 length value (R8 saturation)", int'(len_data), cur_len);
    len_ready = 1'b1;
    @(negedge clk);
    len_ready = 1'b0;
    check(req_ready == 1'b1, "R3 request opens one cycle after length taken", int'(req_ready), 1);
    check(len_valid == 1'b0, "R2 length withdrawn after transfer", int'(len_valid), 0);
  endtask

  task automatic send_req(input int idx, input bit last);
    @(negedge clk);
    req_valid = 1'b1;
    req_index = IDX_W'(idx);
    req_last  = last;
    while (!req_ready) @(negedge clk);
    if (idx < cur_len) expq.push_back({1'b0, model[idx]});
    else               expq.push_back({1'b1, {ELEM_W{1'b0}}});
    @(negedge clk);
    req_valid = 1'b0;
    req_last  = 1'b0;
    check(rsp_valid == 1'b1, "R4 response due one cycle after request", int'(rsp_valid), 1);
    check(req_ready == 1'b0, "R6 request closed while response pending", int'(req_ready), 0);
  endtask

  task automatic finish_seq();
    int t;
    t = 0;
    while (!ld_ready && t < 200) begin
      @(negedge clk);
      t++;
    end
    check(ld_ready == 1'b1, "R7 load reopens after final response", int'(ld_ready), 1);
    check(expq.size() == 0, "R7 all responses delivered before reload", expq.size(), 0);
    check(len_valid == 1'b0, "R7 no length offered before next load", int'(len_valid), 0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(ld_ready && !len_valid && !req_ready && !rsp_valid, "R1 idle during reset",
          int'({ld_ready, len_valid, req_ready, rsp_valid}), 8);
    rst_n = 1'b1;
    @(negedge clk);
    check(ld_ready && !len_valid && !req_ready && !rsp_valid, "R1 idle after reset",
          int'({ld_ready, len_valid, req_ready, rsp_valid}), 8);

    // short sequence, no back-pressure
    bp_mode = 1'b0;
    load_seq(5, 1);
    take_len(2);
    send_req(0, 1'b0);
    send_req(3, 1'b0);
    send_req(4, 1'b0);
    send_req(5, 1'b0);   // R5 index equal to length
    send_req(31, 1'b0);  // R5 largest index
    send_req(2, 1'b1);
    finish_seq();

    // full buffer with random response back-pressure
    bp_mode = 1'b1;
    load_seq(16, 2);
    take_len(0);
    for (int i = 0; i < 24; i++) send_req((i * 11) % 32, i == 23);
    finish_seq();

    // R8 overflow: 20 beats, only 16 kept
    load_seq(20, 3);
    take_len(1);
    send_req(15, 1'b0);
    send_req(16, 1'b0);
    send_req(19, 1'b0);
    send_req(3, 1'b1);
    finish_seq();

    // R7 replacement with a one-element sequence
    bp_mode = 1'b0;
    load_seq(1, 4);
    take_len(0);
    send_req(0, 1'b0);
    send_req(1, 1'b1);
    finish_seq();

    repeat (3) @(negedge clk);
    summary();
    $finish;
  end
endmodule